// File: doc/BRIEF.md
# Framed Serial Word Deserializer with Lock Tracking

This block sits behind a clock-and-data recovery front end. It receives one recovered bit on every fast-clock cycle. Each 12-bit frame on the line holds a start bit (1), ten payload bits and a stop bit (0). The block finds where frames begin, removes the two framing bits and presents each 10-bit payload on a parallel bus with a one-cycle word strobe.

A link comes up when the far end sends a training word of six ones followed by six zeros. While hunting, the block aligns its frame counter to the single rising transition in that word. It asserts its active-low lock output after a run of correctly framed words. Once locked it checks the framing of every frame. It drops lock only when framing fails several frames in a row. Isolated errors withhold the strobe but keep the link up.

The parallel outputs are tri-stated while unlocked. All outputs float when the output enable is low or the block is powered down. Power-down also returns the block to hunting.

Top module: `frame_deser`

## Requirements
- R1: A frame is 12 bits. The block checks a 1 in the first (start) position and a 0 in the last (stop) position. The payload bit received right after the start bit appears on `word_out[0]`, and the bit received just before the stop bit appears on `word_out[9]`.
- R2: `lock_n` is active low. It reads 1 after reset and at all times while the block is hunting.
- R3: While hunting, a 0-to-1 transition on `ser_bit` seen at any position other than the expected start position moves the frame alignment so that the 1 becomes the start bit. Any leading bit offset is therefore absorbed by the training word.
- R4: Lock is declared after 8 consecutive well-framed words at one alignment, and not after 7. A bad frame or a realignment restarts the run.
- R5: While locked, each well-framed word drives its payload onto `word_out` and raises `word_stb` for exactly one cycle. Both occur on the clock edge after the edge that samples the stop bit. The word that completes lock acquisition is not strobed.
- R6: While locked, up to 3 consecutive badly framed words keep lock and produce no strobe. One good frame clears the error run.
- R7: 4 consecutive badly framed words while locked drop lock. `lock_n` goes to 1 on the clock edge after the edge that samples the fourth bad stop bit.
- R8: When enabled but not locked, `word_out` is high-impedance and `word_stb` is driven 0.
- R9: With `out_en` low, `word_out`, `word_stb` and `lock_n` are all high-impedance. Internal lock state and received words are kept and reappear when `out_en` returns high.
- R10: With `pwr_on` low, all outputs are high-impedance and the block is cleared to hunting. After `pwr_on` returns high, `lock_n` reads 1 until a new run of training words achieves lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock, one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on | input | 1 | High for operation; low clears to hunting and floats outputs |
| out_en | input | 1 | High drives the outputs; low floats them |
| ser_bit | input | 1 | Recovered serial bit |
| word_out | output | 10 | Received payload; high-impedance unless locked and enabled |
| word_stb | output | 1 | One-cycle pulse for each good word received while locked |
| lock_n | output | 1 | Active-low lock indicator |

## Verification
The frame counter can be wrong by some number of bits. That fault shows within one frame time as rotated payloads, or as bad-framing counts that drop lock after four frames. A hunting/locked state that is wrong shows on `lock_n` two cycles after the stop bit concerned. In the same frame it also shows as a strobe that is present or missing on `word_stb`. A stale error-run or good-run counter moves lock acquisition or loss by whole frames. The bench therefore checks lock status at one fixed point in every frame. It counts the frames exactly around the 7/8 and 3/4 boundaries.

// File: rtl/fdes_pkg.sv
package fdes_pkg;
  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } link_st_e;
endpackage

// File: rtl/frame_slicer.sv
module frame_slicer #(
  parameter int DATA_W = 10,
  localparam int FRAME_LEN = DATA_W + 2,
  localparam int CW = $clog2(FRAME_LEN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 hunt,
  input  logic                 ser_bit,
  output logic [FRAME_LEN-1:0] frame_q,
  output logic                 frm_done_q,
  output logic                 frm_ok,
  output logic                 resync_q
);
  logic [FRAME_LEN-1:0] sr_q, sr_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic                 done_d, resync_d;
  logic                 rise, realign, last;

  always_comb begin
    rise    = ser_bit & ~sr_q[0];
    realign = hunt & rise & (cnt_q != '0);
    last    = (cnt_q == CW'(FRAME_LEN - 1)) & ~realign;
    if (clr) begin
      cnt_d    = '0;
      sr_d     = '0;
      done_d   = 1'b0;
      resync_d = 1'b0;
    end else begin
      sr_d     = {sr_q[FRAME_LEN-2:0], ser_bit};
      done_d   = last;
      resync_d = realign;
      if (realign)   cnt_d = CW'(1);
      else if (last) cnt_d = '0;
      else           cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q       <= '0;
      cnt_q      <= '0;
      frm_done_q <= 1'b0;
      resync_q   <= 1'b0;
    end else begin
      sr_q       <= sr_d;
      cnt_q      <= cnt_d;
      frm_done_q <= done_d;
      resync_q   <= resync_d;
    end
  end

  assign frame_q = sr_q;
  assign frm_ok  = sr_q[FRAME_LEN-1] & ~sr_q[0];

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(FRAME_LEN));
  assert_done_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done_q |=> !frm_done_q);
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import fdes_pkg::*;
#(
  parameter int LOCK_RUN   = 8,
  parameter int MISS_LIMIT = 4,
  localparam int GW = (LOCK_RUN > 2) ? $clog2(LOCK_RUN) : 1,
  localparam int MW = (MISS_LIMIT > 2) ? $clog2(MISS_LIMIT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic frm_done,
  input  logic frm_ok,
  input  logic resync,
  output logic locked
);
  link_st_e      st_q, st_d;
  logic [GW-1:0] good_q, good_d;
  logic [MW-1:0] miss_q, miss_d;

  always_comb begin
    st_d   = st_q;
    good_d = good_q;
    miss_d = miss_q;
    if (clr) begin
      st_d   = ST_HUNT;
      good_d = '0;
      miss_d = '0;
    end else begin
      case (st_q)
        ST_HUNT: begin
          if (resync) good_d = '0;
          else if (frm_done) begin
            if (!frm_ok) good_d = '0;
            else if (good_q == GW'(LOCK_RUN - 1)) begin
              st_d   = ST_LOCK;
              good_d = '0;
              miss_d = '0;
            end else good_d = good_q + GW'(1);
          end
        end
        default: begin
          if (frm_done) begin
            if (frm_ok) miss_d = '0;
            else if (miss_q == MW'(MISS_LIMIT - 1)) begin
              st_d   = ST_HUNT;
              miss_d = '0;
              good_d = '0;
            end else miss_d = miss_q + MW'(1);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      good_q <= '0;
      miss_q <= '0;
    end else begin
      st_q   <= st_d;
      good_q <= good_d;
      miss_q <= miss_d;
    end
  end

  assign locked = (st_q == ST_LOCK);

  assert_lock_after_good_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(frm_done && frm_ok));
  assert_unlock_after_bad_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(locked) && $past(!clr)) |-> $past(frm_done && !frm_ok));
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int DATA_W = 10,
  localparam int FRAME_LEN = DATA_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 locked,
  input  logic                 frm_done,
  input  logic                 frm_ok,
  input  logic [FRAME_LEN-1:0] frame,
  output logic [DATA_W-1:0]    word_q,
  output logic                 stb_q
);
  logic [DATA_W-1:0] pay, word_d;
  logic              take, stb_d;

  for (genvar i = 0; i < DATA_W; i++) begin : g_pay
    assign pay[i] = frame[FRAME_LEN-2-i];
  end

  always_comb begin
    take   = ~clr & frm_done & frm_ok & locked;
    stb_d  = take;
    word_d = take ? pay : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      stb_q  <= stb_d;
    end
  end

  assert_stb_only_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> $past(locked));
  assert_stb_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);
endmodule

// File: rtl/frame_deser.sv
module frame_deser #(
  parameter int DATA_W     = 10,
  parameter int LOCK_RUN   = 8,
  parameter int MISS_LIMIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on,
  input  logic              out_en,
  input  logic              ser_bit,
  output logic [DATA_W-1:0] word_out,
  output logic              word_stb,
  output logic              lock_n
);
  localparam int FRAME_LEN = DATA_W + 2;

  logic [FRAME_LEN-1:0] frame;
  logic [DATA_W-1:0]    word_q;
  logic                 frm_done, frm_ok, resync, locked, stb_q, clr;
  logic                 drv_lock, drv_data;

  assign clr = ~pwr_on;

  frame_slicer #(.DATA_W(DATA_W)) u_slice (
    .clk(clk), .rst_n(rst_n), .clr(clr), .hunt(~locked), .ser_bit(ser_bit),
    .frame_q(frame), .frm_done_q(frm_done), .frm_ok(frm_ok), .resync_q(resync)
  );

  lock_fsm #(.LOCK_RUN(LOCK_RUN), .MISS_LIMIT(MISS_LIMIT)) u_lock (
    .clk(clk), .rst_n(rst_n), .clr(clr), .frm_done(frm_done), .frm_ok(frm_ok),
    .resync(resync), .locked(locked)
  );

  out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .clr(clr), .locked(locked), .frm_done(frm_done),
    .frm_ok(frm_ok), .frame(frame), .word_q(word_q), .stb_q(stb_q)
  );

  assign drv_lock = out_en & pwr_on;
  assign drv_data = drv_lock & locked;
  assign lock_n   = drv_lock ? ~locked : 1'bz;
  assign word_stb = drv_lock ? stb_q : 1'bz;
  assign word_out = drv_data ? word_q : {DATA_W{1'bz}};
endmodule

// File: tb/sim_frame_deser.sv
module sim_frame_deser;
  logic       clk, rst_n, pwr_on, out_en, ser_bit;
  wire  [9:0] word_out;
  wire        word_stb, lock_n;

  int n_run, n_fail;
  logic       s_lock, s_stb, s_stb2;
  logic [9:0] s_word;

  localparam logic [9:0] SYNC = 10'b0000011111;

  frame_deser u0 (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .out_en(out_en), .ser_bit(ser_bit),
    .word_out(word_out), .word_stb(word_stb), .lock_n(lock_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk1(string tag, logic got, logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic chkw(string tag, logic [9:0] got, logic [9:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // Sends one frame; samples the outputs for the previous frame at bit slots 1 and 2.
  task automatic send_frame(logic st, logic [9:0] d, logic sp);
    logic [11:0] bits;
    bits = {sp, d[9:0], st};
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (i == 1) begin
        s_lock = lock_n; s_stb = word_stb; s_word = word_out;
      end
      if (i == 2) s_stb2 = word_stb;
      ser_bit = bits[i];
    end
  endtask

  task automatic send_raw(logic b);
    @(negedge clk);
    ser_bit = b;
  endtask

  task automatic t_reset;
    chk1("R2 reset lock_n", lock_n, 1'b1);
    chk1("R8 reset stb", word_stb, 1'b0);
    chkw("R8 reset word Z", word_out, 10'bz);
  endtask

  task automatic t_acquire;
    send_raw(1'b1); send_raw(1'b0); send_raw(1'b1); send_raw(1'b1); send_raw(1'b0);
    for (int f = 0; f < 8; f++) begin
      send_frame(1'b1, SYNC, 1'b0);
      if (f == 7) chk1("R4 no lock after 7", s_lock, 1'b1);
    end
    send_frame(1'b1, 10'h001, 1'b0);
    chk1("R3 R4 locked after 8 with offset", s_lock, 1'b0);
    chk1("R5 lock-completing word not strobed", s_stb, 1'b0);
  endtask

  task automatic t_data;
    send_frame(1'b1, 10'h200, 1'b0);
    chk1("R5 strobe", s_stb, 1'b1);
    chkw("R1 bit0 first", s_word, 10'h001);
    chk1("R5 strobe one cycle", s_stb2, 1'b0);
    send_frame(1'b1, 10'h2A5, 1'b0);
    chkw("R1 bit9 last", s_word, 10'h200);
    send_frame(1'b1, 10'h000, 1'b0);
    chkw("R1 mixed word", s_word, 10'h2A5);
    chk1("R5 strobe mixed", s_stb, 1'b1);
  endtask

  task automatic t_errors;
    send_frame(1'b1, 10'h111, 1'b1);
    send_frame(1'b0, 10'h122, 1'b0);
    chk1("R6 bad frame no strobe", s_stb, 1'b0);
    send_frame(1'b1, 10'h133, 1'b1);
    send_frame(1'b1, 10'h0F0, 1'b0);
    chk1("R6 three bad keep lock", s_lock, 1'b0);
    send_frame(1'b1, 10'h144, 1'b1);
    chk1("R6 good clears run strobe", s_stb, 1'b1);
    chkw("R6 good word after errors", s_word, 10'h0F0);
    send_frame(1'b1, 10'h155, 1'b1);
    send_frame(1'b0, 10'h166, 1'b1);
    send_frame(1'b1, 10'h0AA, 1'b0);
    chk1("R6 run restarted, still locked", s_lock, 1'b0);
    send_frame(1'b1, 10'h177, 1'b1);
    send_frame(1'b1, 10'h188, 1'b1);
    send_frame(1'b1, 10'h199, 1'b1);
    send_frame(1'b1, 10'h1AA, 1'b1);
    chk1("R7 three of four still locked", s_lock, 1'b0);
    send_frame(1'b1, SYNC, 1'b0);
    chk1("R7 lock lost after four", s_lock, 1'b1);
    chk1("R8 unlocked stb low", s_stb, 1'b0);
    chkw("R8 unlocked word Z", s_word, 10'bz);
    for (int f = 0; f < 8; f++) send_frame(1'b1, SYNC, 1'b0);
    send_frame(1'b1, 10'h0C3, 1'b0);
    chk1("R4 relock after loss", s_lock, 1'b0);
  endtask

  task automatic t_enable;
    out_en = 1'b0;
    send_frame(1'b1, 10'h3C0, 1'b0);
    chk1("R9 lock_n Z", s_lock, 1'bz);
    chk1("R9 stb Z", s_stb, 1'bz);
    chkw("R9 word Z", s_word, 10'bz);
    out_en = 1'b1;
    send_frame(1'b1, 10'h000, 1'b0);
    chk1("R9 lock kept", s_lock, 1'b0);
    chkw("R9 word kept", s_word, 10'h3C0);
  endtask

  task automatic t_power;
    pwr_on = 1'b0;
    send_frame(1'b1, 10'h055, 1'b0);
    chk1("R10 lock_n Z", s_lock, 1'bz);
    chkw("R10 word Z", s_word, 10'bz);
    pwr_on = 1'b1;
    send_frame(1'b1, SYNC, 1'b0);
    chk1("R10 cleared to hunting", s_lock, 1'b1);
    for (int f = 0; f < 7; f++) send_frame(1'b1, SYNC, 1'b0);
    send_frame(1'b1, 10'h3FF, 1'b0);
    chk1("R10 relock after power-up", s_lock, 1'b0);
  endtask

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; pwr_on = 1'b1; out_en = 1'b1; ser_bit = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_acquire;
    t_data;
    t_errors;
    t_enable;
    t_power;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule